// File: doc/BRIEF.md
# Test-and-Set Semaphore Bank

This block is a small set of one-bit lock registers. It sits in a reserved window of the shared data-memory map and answers like any plain slave on the data interconnect. Software assigns one register to each shared data structure it needs to guard. A read is an atomic test-and-set. It returns the value the register held and leaves it locked. A write sets the register's state directly. Writing zero frees it, and writing any non-zero value locks it. Cores build spin locks and one- or two-phase barriers from these two operations.

Several master ports reach the bank, and every request is accepted in the cycle it is raised. When more than one port touches the same register in one cycle, the accesses are resolved in port-index order, with port 0 first. Each later port sees the register as the earlier ports left it. Each register is a two-state machine. Its states are `SEM_FREE` and `SEM_HELD`. It has three transitions:

- *acquire*: a read moves `SEM_FREE` to `SEM_HELD`.
- *release*: a write of zero moves `SEM_HELD` to `SEM_FREE`.
- *force*: a non-zero write moves either state to `SEM_HELD`.

A read in `SEM_HELD` leaves the state where it is.

Top module: `sem_bank`

## Requirements
- R1: After reset every register is in `SEM_FREE`. While reset is held, `rvalid_o` is all zero.
- R2: A read of a free register returns 0 and leaves that register held, so the next read of it returns 1.
- R3: A read of a held register returns 1 and leaves the register held.
- R4: A write of 0 releases the register. A write of any non-zero value makes it held, whatever its previous state was.
- R5: When several ports read the same register in one cycle, only the lowest-indexed of them can receive 0. Every other reading port receives 1.
- R6: When several ports access one register in the same cycle, they act in ascending port order, and each port sees the effect of the lower-indexed ports. A write of 0 on port 0 followed by a read on port 1 gives port 1 the value 0 and leaves the register held.
- R7: An address whose value is NUM_SEM or more selects no register. A read of it returns 0 with `rvalid_o` set, and a write to it changes no register.
- R8: `gnt_o[p]` is high in the same cycle as `req_i[p]`. Read data and `rvalid_o[p]` appear exactly one cycle after a granted read. A write produces no `rvalid_o`.
- R9: Accesses to different registers in the same cycle do not affect each other.
- R10: Read data is DATA_W bits wide. It holds the lock value 0 or 1 in bit 0, and all upper bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_PORTS | Access request, one bit per port |
| we_i | input | NUM_PORTS | 1 = write, 0 = test-and-set read, per port |
| addr_i | input | NUM_PORTS*ADDR_W | Register index, port p in bits [p*ADDR_W +: ADDR_W] |
| wdata_i | input | NUM_PORTS*DATA_W | Write data, zero releases and non-zero locks |
| gnt_o | output | NUM_PORTS | Same-cycle grant |
| rvalid_o | output | NUM_PORTS | Read response valid, one cycle after the read |
| rdata_o | output | NUM_PORTS*DATA_W | Previous lock value, zero-extended |

## Verification
The hardest situation to reach from the ports is a collision inside one cycle. This happens when two ports hit the same register together, either as two reads racing for a free lock or as a release on one port and an acquire on the other. The order-dependent chain inside each register only matters in that case. The scenario tasks drive both ports in the same cycle, away from the clock edge. They then read the register back in a later cycle to confirm which port won and what state was left behind. Out-of-range writes use addresses whose low bits alias a real register, so that a decode fault would show up on that register.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_HELD = 1'b1
    } sem_state_t;
endpackage

// File: rtl/sem_cell.sv
// One lock register. Accesses from all ports in a cycle are applied
// in ascending port order; each port sees the state left by the ones before it.
module sem_cell
    import sem_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PORTS-1:0] hit_i,
    input  logic [NUM_PORTS-1:0] we_i,
    input  logic [NUM_PORTS-1:0] wset_i,
    output logic [NUM_PORTS-1:0] seen_o
);
    sem_state_t state_q;
    sem_state_t state_d;

    // Ordered resolution of the ports and output values
    always_comb begin
        sem_state_t walk;
        walk = state_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            seen_o[p] = (walk == SEM_HELD);
            if (hit_i[p]) begin
                if (we_i[p]) begin
                    unique case (wset_i[p])
                        1'b1: walk = SEM_HELD;   // force
                        1'b0: walk = SEM_FREE;   // release
                    endcase
                end else begin
                    walk = SEM_HELD;             // acquire, or stay held
                end
            end
        end
        state_d = walk;
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SEM_FREE;
        else         state_q <= state_d;
    end

    logic any_rd;
    logic any_wr;
    assign any_rd = |(hit_i & ~we_i);
    assign any_wr = |(hit_i & we_i);

    p_read_locks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_rd && !any_wr) |=> (state_q == SEM_HELD));

    p_held_read_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEM_HELD && !any_wr) |=> (state_q == SEM_HELD));

    p_single_winner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_wr |-> ($countones(hit_i & ~we_i & ~seen_o) <= 1));

    p_untouched_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i == '0) |=> $stable(state_q));
endmodule

// File: rtl/sem_port_rsp.sv
// Registered read response for one master port.
module sem_port_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fire_i,
    input  logic              bit_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic valid_q;
    logic bit_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            valid_q <= fire_i;
            bit_q   <= fire_i & bit_i;
        end
    end

    always_comb begin
        rvalid_o = valid_q;
        rdata_o  = {{(DATA_W-1){1'b0}}, bit_q};
    end

    p_rdata_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> (rdata_o <= DATA_W'(1)));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_SEM   = 8,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_PORTS-1:0]          req_i,
    input  logic [NUM_PORTS-1:0]          we_i,
    input  logic [NUM_PORTS*ADDR_W-1:0]   addr_i,
    input  logic [NUM_PORTS*DATA_W-1:0]   wdata_i,
    output logic [NUM_PORTS-1:0]          gnt_o,
    output logic [NUM_PORTS-1:0]          rvalid_o,
    output logic [NUM_PORTS*DATA_W-1:0]   rdata_o
);
    logic [NUM_PORTS-1:0] in_range;
    logic [NUM_PORTS-1:0] wset;
    logic [NUM_PORTS-1:0] rd_fire;
    logic [NUM_PORTS-1:0] rd_bit;
    logic [NUM_PORTS-1:0] hit  [NUM_SEM];
    logic [NUM_PORTS-1:0] seen [NUM_SEM];

    // Every request is served in the cycle it arrives
    assign gnt_o = req_i;

    // Address decode per port
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            in_range[p] = int'(addr_i[p*ADDR_W +: ADDR_W]) < NUM_SEM;
            wset[p]     = |wdata_i[p*DATA_W +: DATA_W];
            rd_fire[p]  = req_i[p] & ~we_i[p];
        end
        for (int s = 0; s < NUM_SEM; s++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                hit[s][p] = req_i[p] & in_range[p] &
                            (addr_i[p*ADDR_W +: ADDR_W] == ADDR_W'(s));
            end
        end
    end

    // Collect the value each port saw
    always_comb begin
        rd_bit = '0;
        for (int s = 0; s < NUM_SEM; s++) begin
            rd_bit = rd_bit | (hit[s] & seen[s]);
        end
    end

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_cell
        sem_cell #(.NUM_PORTS(NUM_PORTS)) cell_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .hit_i  (hit[s]),
            .we_i   (we_i),
            .wset_i (wset),
            .seen_o (seen[s])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sem_port_rsp #(.DATA_W(DATA_W)) rsp_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .fire_i   (rd_fire[p]),
            .bit_i    (rd_bit[p]),
            .rvalid_o (rvalid_o[p]),
            .rdata_o  (rdata_o[p*DATA_W +: DATA_W])
        );

        p_rvalid_after_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rvalid_o[p] |-> $past(req_i[p] && !we_i[p]));

        p_no_rvalid_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i[p] && we_i[p]) |=> !rvalid_o[p]);

        p_oor_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (req_i[p] && !we_i[p] && !in_range[p]) |=> (rdata_o[p*DATA_W +: DATA_W] == '0));
    end

    // R1: no response while reset is held
    always @(posedge clk_i) begin
        if (!rst_ni) p_reset_quiet_r1: assert (rvalid_o == '0);
    end
endmodule

// File: tb/sem_bank_tb_top.sv
module sem_bank_tb_top;
    localparam int P  = 2;
    localparam int NS = 8;
    localparam int AW = 4;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [P-1:0]      req = '0;
    logic [P-1:0]      we = '0;
    logic [P*AW-1:0]   addr = '0;
    logic [P*DW-1:0]   wdata = '0;
    logic [P-1:0]      gnt;
    logic [P-1:0]      rvalid;
    logic [P*DW-1:0]   rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sem_bank #(.NUM_PORTS(P), .NUM_SEM(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req = '0; we = '0; addr = '0; wdata = '0;
    endtask

    task automatic put(input int p, input bit w, input int a, input logic [DW-1:0] d);
        req[p] = 1'b1;
        we[p]  = w;
        addr[p*AW +: AW]  = AW'(a);
        wdata[p*DW +: DW] = d;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input int p, input int a, input logic [DW-1:0] exp, input string tag);
        idle();
        put(p, 1'b0, a, '0);
        check({tag, " R8 grant"}, DW'(gnt[p]), 1);
        step();
        check({tag, " R8 rvalid"}, DW'(rvalid[p]), 1);
        check(tag, rdata[p*DW +: DW], exp);
        idle();
    endtask

    task automatic wr(input int p, input int a, input logic [DW-1:0] d);
        idle();
        put(p, 1'b1, a, d);
        step();
        check("R8 no rvalid on write", DW'(rvalid[p]), 0);
        idle();
    endtask

    task automatic t_reset();
        check("R1 rvalid in reset", DW'(rvalid), 0);
        for (int s = 0; s < NS; s++) rd(0, s, 0, "R1 free after reset");
        for (int s = 0; s < NS; s++) rd(1, s, 1, "R2 locked by first read");
        for (int s = 0; s < NS; s++) wr(0, s, 0);
        step();
        check("R8 rvalid drops", DW'(rvalid), 0);
    endtask

    task automatic t_lock();
        rd(0, 3, 0, "R2 acquire");
        rd(1, 3, 1, "R3 held denies");
        rd(0, 3, 1, "R3 still held");
        wr(1, 3, 0);
        rd(1, 3, 0, "R4 release then acquire");
        wr(0, 3, 0);
        wr(0, 3, 32'h8000_0000);
        rd(1, 3, 1, "R4 nonzero write forces held");
        wr(0, 3, 0);
        rd(0, 3, 0, "R4 zero write frees");
        wr(0, 3, 0);
    endtask

    task automatic t_race();
        idle();
        put(0, 1'b0, 5, '0);
        put(1, 1'b0, 5, '0);
        check("R8 dual grant", DW'(gnt), 3);
        step();
        check("R5 port0 wins", rdata[0 +: DW], 0);
        check("R5 port1 loses", rdata[DW +: DW], 1);
        check("R5 both valid", DW'(rvalid), 3);
        idle();
        put(0, 1'b0, 5, '0);
        put(1, 1'b0, 5, '0);
        step();
        check("R5 held both denied p0", rdata[0 +: DW], 1);
        check("R5 held both denied p1", rdata[DW +: DW], 1);
        idle();
        wr(0, 5, 0);
    endtask

    task automatic t_order();
        rd(0, 2, 0, "R6 setup lock");
        idle();
        put(0, 1'b1, 2, 0);
        put(1, 1'b0, 2, '0);
        step();
        check("R6 release before read", rdata[DW +: DW], 0);
        check("R6 writer no rvalid", DW'(rvalid[0]), 0);
        idle();
        rd(0, 2, 1, "R6 left held by port1");
        wr(0, 2, 0);
        idle();
        put(0, 1'b0, 6, '0);
        put(1, 1'b1, 6, 0);
        step();
        check("R6 read before release", rdata[0 +: DW], 0);
        idle();
        rd(0, 6, 0, "R6 later release wins");
        wr(0, 6, 0);
    endtask

    task automatic t_oor();
        wr(0, 9, 1);
        wr(1, 15, 32'hFFFF_FFFF);
        rd(0, 12, 0, "R7 oor read zero");
        rd(1, 8, 0, "R7 oor read zero p1");
        for (int s = 0; s < NS; s++) rd(0, s, 0, "R7 oor write no effect");
        for (int s = 0; s < NS; s++) wr(0, s, 0);
    endtask

    task automatic t_indep();
        rd(0, 7, 0, "R9 setup lock 7");
        idle();
        put(0, 1'b0, 1, '0);
        put(1, 1'b1, 7, 0);
        step();
        check("R9 p0 acquires 1", rdata[0 +: DW], 0);
        idle();
        put(0, 1'b0, 7, '0);
        put(1, 1'b0, 4, '0);
        step();
        check("R9 7 released", rdata[0 +: DW], 0);
        check("R9 4 free", rdata[DW +: DW], 0);
        idle();
        rd(1, 1, 1, "R10 held reads exactly 1");
        for (int s = 0; s < NS; s++) wr(0, s, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #20;
        @(negedge clk);
        #1;
        t_reset_pre: check("R1 rvalid low in reset", DW'(rvalid), 0);
        rst_n = 1'b1;
        step();
        t_reset();
        t_lock();
        t_race();
        t_order();
        t_oor();
        t_indep();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule